// File: doc/BRIEF.md
# I2C Command-Mode Conversion Sequencer

This block is the I2C target side of a multi-channel 12-bit converter. It works in command mode. A controller selects a pointer, writes a channel bitmask to the command register, and then issues a repeated start into a read transaction. Each selected channel is converted in ascending order, and every result leaves the block as two read bytes. The next conversion is launched when the high byte of the current result is fetched. Reading the result and converting the next channel therefore overlap.

The I2C bus is seen through a decoded event port. It carries single-cycle pulses for start or repeated start, stop, an address header with its direction bit, a written data byte, a request for a read byte, and the controller's acknowledge or not-acknowledge. On the other side a request/done handshake drives an abstract converter, and at most one conversion is in flight at a time. Command mode ends on a controller NACK, on a stop condition, or when no read byte is requested for a timeout period derived from the clock frequency.

The control state machine has these states. IDLE waits for a start. HDR waits for the header: a read goes to RD_HI and a write goes to WR_PTR. WR_PTR takes the pointer byte: pointer 0x00 goes to WR_CMD, any other value goes to WR_IGN. WR_CMD takes the mask and goes to WR_NEWPTR. WR_NEWPTR takes an optional new pointer and goes to WR_IGN. WR_IGN discards bytes. A read request moves RD_HI to RD_LO and RD_LO back to RD_HI. A NACK in either read state leads to IDLE. From every state, a stop leads to IDLE and a start leads to HDR.

Top module: `cmd_adc_seq`

## Requirements
- R1: A nonzero mask byte written after pointer 0x00 enters command mode and raises `o_conv_req` in the next cycle for the lowest selected channel.
- R2: After the mask byte the pointer goes back to the value it held before the pointer byte of that write. A further byte in the same write becomes the new pointer and does not disturb the conversion sequence.
- R3: A result is read as a high byte {alert, channel[2:0], value[11:8]} (bit 7 down to bit 0) followed by a low byte value[7:0].
- R4: In command mode, each high-byte read request launches the conversion of the next selected channel. That result is delivered by the next byte pair.
- R5: The channel number equals the bit position in the mask. Channels are visited in ascending order, and the scan wraps to the lowest selected channel.
- R6: Mask bits at positions N_CH and above are discarded. A mask that is zero after this does not enter command mode and launches no conversion. Pointer 0x00 reads back as 0x00 then the stored mask.
- R7: A NACK from the controller on a read byte ends command mode, so later reads launch no conversion.
- R8: A stop ends command mode. After a stop and a fresh start, reads return the result register and launch no conversion.
- R9: Command mode ends once TIMEOUT_US microseconds of clock cycles pass with no read request.
- R10: A result byte requested before the pending conversion completes returns the last completed result. A launch requested while a conversion is in flight is deferred until the converter is done.
- R11: The alert bit of a result is `i_alert` as sampled in the cycle `i_conv_done` is high.
- R12: Outside command mode a read returns two bytes, high then low, of the addressed register. Pointer 0x01 gives the last result word and any other pointer except 0x00 gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_start | input | 1 | Start or repeated start seen on the bus |
| i_stop | input | 1 | Stop seen on the bus |
| i_hdr_valid | input | 1 | Address header addressed to this target |
| i_hdr_read | input | 1 | Direction bit of the header (1 = read) |
| i_wr_valid | input | 1 | A written data byte is present |
| i_wr_data | input | 8 | Written data byte |
| i_rd_req | input | 1 | Controller starts reading a byte |
| i_rd_ack_valid | input | 1 | Controller acknowledge phase for a read byte |
| i_rd_nack | input | 1 | Acknowledge phase value: 1 = NACK |
| o_rd_data | output | 8 | Byte to transmit, valid the cycle after `i_rd_req` |
| o_conv_req | output | 1 | One-cycle conversion launch |
| o_conv_ch | output | 3 | Channel of the launched conversion |
| i_conv_done | input | 1 | Converter result valid |
| i_conv_value | input | 12 | Converter result |
| i_alert | input | 1 | Alert flag, sampled with each result |

## Verification
The embedded properties assume a well-formed event stream. Each event is a single-cycle pulse, start and stop never coincide with each other or with a data event, and an acknowledge phase follows only a read byte. They also assume the converter raises `i_conv_done` once per launch and only while a conversion is in flight. The bench keeps to these limits: every bus event is driven as its own pulse with idle cycles between events, and the converter model answers each launch once, after a programmable latency. The bench also flags any launch that arrives while the model is still busy.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WR_PTR,
        ST_WR_CMD,
        ST_WR_NEWPTR,
        ST_WR_IGN,
        ST_RD_HI,
        ST_RD_LO
    } seq_state_e;

    // Layout of one result word as it leaves on the bus (high byte first)
    typedef struct packed {
        logic        alert;
        logic [2:0]  chan;
        logic [11:0] value;
    } result_t;

    localparam logic [7:0] PTR_CMD    = 8'h00;
    localparam logic [7:0] PTR_RESULT = 8'h01;

endpackage

// File: rtl/cmdseq_scan.sv
module cmdseq_scan #(
    parameter int N_CH = 6
) (
    input  logic [7:0] mask_first,
    input  logic [7:0] mask_next,
    input  logic [2:0] cur,
    output logic [2:0] first_ch,
    output logic [2:0] next_ch
);

    logic [2:0] wrap_ch;

    // Lowest set bit of mask_first; lowest set bit of mask_next above cur,
    // falling back to its lowest set bit.
    always_comb begin
        first_ch = '0;
        wrap_ch  = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (mask_first[i]) first_ch = 3'(i);
            if (mask_next[i])  wrap_ch  = 3'(i);
        end
        next_ch = wrap_ch;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (mask_next[i] && (i > int'(cur))) next_ch = 3'(i);
        end
    end

endmodule

// File: rtl/cmdseq_timer.sv
module cmdseq_timer #(
    parameter int CYCLES = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expire
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && (cnt_q == CW'(CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || clear || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TIMER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(CYCLES)); // R9

endmodule

// File: rtl/cmdseq_regword.sv
module cmdseq_regword
    import cmdseq_pkg::*;
(
    input  logic [7:0] ptr,
    input  logic [7:0] mask,
    input  logic       cmd_on,
    input  result_t    live,
    output logic [15:0] word
);

    always_comb begin
        if (cmd_on || ptr == PTR_RESULT) begin
            word = live;
        end else if (ptr == PTR_CMD) begin
            word = {8'h00, mask};
        end else begin
            word = 16'h0000;
        end
    end

endmodule

// File: rtl/cmd_adc_seq.sv
module cmd_adc_seq
    import cmdseq_pkg::*;
#(
    parameter int N_CH       = 6,
    parameter int CLK_HZ     = 125_000_000,
    parameter int TIMEOUT_US = 5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        i_start,
    input  logic        i_stop,
    input  logic        i_hdr_valid,
    input  logic        i_hdr_read,
    input  logic        i_wr_valid,
    input  logic [7:0]  i_wr_data,
    input  logic        i_rd_req,
    input  logic        i_rd_ack_valid,
    input  logic        i_rd_nack,
    output logic [7:0]  o_rd_data,
    output logic        o_conv_req,
    output logic [2:0]  o_conv_ch,
    input  logic        i_conv_done,
    input  logic [11:0] i_conv_value,
    input  logic        i_alert
);

    localparam int         TO_CYC     = (CLK_HZ / 1_000_000) * TIMEOUT_US;
    localparam logic [7:0] MASK_VALID = 8'((1 << N_CH) - 1);

    seq_state_e state_q, state_d;
    logic [7:0] ptr_q, prev_ptr_q, mask_q, snap_lo_q, rd_data_q;
    logic [2:0] cur_ch_q, conv_ch_q, pend_ch_q;
    logic       cmd_on_q, conv_req_q, busy_q, pend_q;
    result_t    live_q;

    logic [7:0]  cmd_mask;
    logic [2:0]  first_ch, next_ch, want_ch;
    logic        want_req, cmd_wr, to_expire, nack_ev;
    logic [15:0] word;

    assign cmd_mask = i_wr_data & MASK_VALID;
    assign cmd_wr   = (state_q == ST_WR_CMD) && i_wr_valid;
    assign nack_ev  = i_rd_ack_valid && i_rd_nack;
    assign want_req = (cmd_wr && cmd_mask != 8'h00) ||
                      ((state_q == ST_RD_HI) && i_rd_req && cmd_on_q);
    assign want_ch  = cmd_wr ? first_ch : next_ch;

    cmdseq_scan #(.N_CH(N_CH)) u_scan (
        .mask_first (cmd_mask),
        .mask_next  (mask_q),
        .cur        (cur_ch_q),
        .first_ch   (first_ch),
        .next_ch    (next_ch)
    );

    cmdseq_timer #(.CYCLES(TO_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cmd_on_q),
        .clear  (i_rd_req || cmd_wr),
        .expire (to_expire)
    );

    cmdseq_regword u_word (
        .ptr    (ptr_q),
        .mask   (mask_q),
        .cmd_on (cmd_on_q),
        .live   (live_q),
        .word   (word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (i_stop) begin
            state_d = ST_IDLE;
        end else if (i_start) begin
            state_d = ST_HDR;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_HDR:       if (i_hdr_valid) state_d = i_hdr_read ? ST_RD_HI : ST_WR_PTR;
                ST_WR_PTR:    if (i_wr_valid) state_d = (i_wr_data == PTR_CMD) ? ST_WR_CMD : ST_WR_IGN;
                ST_WR_CMD:    if (i_wr_valid) state_d = ST_WR_NEWPTR;
                ST_WR_NEWPTR: if (i_wr_valid) state_d = ST_WR_IGN;
                ST_WR_IGN:    state_d = ST_WR_IGN;
                ST_RD_HI:     if (i_rd_req) state_d = ST_RD_LO; else if (nack_ev) state_d = ST_IDLE;
                ST_RD_LO:     if (i_rd_req) state_d = ST_RD_HI; else if (nack_ev) state_d = ST_IDLE;
            endcase
        end
    end

    // Registers, command mode and converter handshake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            prev_ptr_q <= '0;
            mask_q     <= '0;
            snap_lo_q  <= '0;
            rd_data_q  <= '0;
            cur_ch_q   <= '0;
            conv_ch_q  <= '0;
            pend_ch_q  <= '0;
            cmd_on_q   <= 1'b0;
            conv_req_q <= 1'b0;
            busy_q     <= 1'b0;
            pend_q     <= 1'b0;
            live_q     <= '0;
        end else begin
            conv_req_q <= 1'b0;
            if (i_conv_done) begin
                live_q <= '{alert: i_alert, chan: conv_ch_q, value: i_conv_value};
                busy_q <= 1'b0;
            end
            case (state_q)
                ST_WR_PTR: if (i_wr_valid) begin
                    prev_ptr_q <= ptr_q;
                    ptr_q      <= i_wr_data;
                end
                ST_WR_CMD: if (i_wr_valid) begin
                    mask_q   <= cmd_mask;
                    ptr_q    <= prev_ptr_q;
                    cmd_on_q <= (cmd_mask != 8'h00);
                end
                ST_WR_NEWPTR: if (i_wr_valid) ptr_q <= i_wr_data;
                ST_RD_HI: if (i_rd_req) begin
                    rd_data_q <= word[15:8];
                    snap_lo_q <= word[7:0];
                end
                ST_RD_LO: if (i_rd_req) rd_data_q <= snap_lo_q;
                default: ;
            endcase
            if (want_req) begin
                cur_ch_q <= want_ch;
                if (busy_q && !i_conv_done) begin
                    pend_q    <= 1'b1;
                    pend_ch_q <= want_ch;
                end else begin
                    conv_req_q <= 1'b1;
                    conv_ch_q  <= want_ch;
                    busy_q     <= 1'b1;
                end
            end else if (pend_q && i_conv_done) begin
                pend_q     <= 1'b0;
                conv_req_q <= 1'b1;
                conv_ch_q  <= pend_ch_q;
                busy_q     <= 1'b1;
            end
            if (i_stop || to_expire || nack_ev) cmd_on_q <= 1'b0;
        end
    end

    assign o_rd_data  = rd_data_q;
    assign o_conv_req = conv_req_q;
    assign o_conv_ch  = conv_ch_q;

    AST_FIRST_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && (cmd_mask != 8'h00) && !i_stop && !busy_q |=> o_conv_req && cmd_on_q); // R1
    AST_NEXT_ON_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_HI) && i_rd_req && cmd_on_q && !busy_q |=> o_conv_req); // R4
    AST_CHAN_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        o_conv_req |-> mask_q[o_conv_ch]); // R5
    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && (cmd_mask == 8'h00) && !pend_q |=> !cmd_on_q && !o_conv_req); // R6
    AST_NACK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        nack_ev && !cmd_wr |=> !cmd_on_q); // R7
    AST_STOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        i_stop |=> !cmd_on_q); // R8
    AST_TIMEOUT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        to_expire && !cmd_wr |=> !cmd_on_q); // R9
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !i_conv_done |=> $stable(live_q)); // R10
    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !i_conv_done |=> !o_conv_req); // R10
    AST_ALERT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        i_conv_done |=> live_q.alert == $past(i_alert)); // R11

endmodule

// File: tb/test_cmd_adc_seq.sv
module test_cmd_adc_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_start = 0, i_stop = 0, i_hdr_valid = 0, i_hdr_read = 0;
    logic        i_wr_valid = 0, i_rd_req = 0, i_rd_ack_valid = 0, i_rd_nack = 0;
    logic [7:0]  i_wr_data = '0;
    logic [7:0]  o_rd_data;
    logic        o_conv_req;
    logic [2:0]  o_conv_ch;
    logic        i_conv_done = 1'b0;
    logic [11:0] i_conv_value = '0;
    logic        i_alert = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    cmd_adc_seq #(.N_CH(6), .CLK_HZ(125_000_000), .TIMEOUT_US(1)) i_cmd_adc_seq (
        .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_stop(i_stop),
        .i_hdr_valid(i_hdr_valid), .i_hdr_read(i_hdr_read),
        .i_wr_valid(i_wr_valid), .i_wr_data(i_wr_data),
        .i_rd_req(i_rd_req), .i_rd_ack_valid(i_rd_ack_valid), .i_rd_nack(i_rd_nack),
        .o_rd_data(o_rd_data), .o_conv_req(o_conv_req), .o_conv_ch(o_conv_ch),
        .i_conv_done(i_conv_done), .i_conv_value(i_conv_value), .i_alert(i_alert)
    );

    always #4 clk = ~clk;

    // Scoreboard queues
    logic [7:0] exp_b_q[$];
    string      exp_b_tag[$];
    logic [2:0] exp_c_q[$];
    string      exp_c_tag[$];
    logic [7:0] got_byte;
    event       byte_ev;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expected result bytes: value = {chan, 1'b0, k[7:0]}, alert = k[0]
    function automatic logic [7:0] hi_b(input int k, input logic [2:0] c);
        return {k[0], c, c, 1'b0};
    endfunction
    function automatic logic [7:0] lo_b(input int k);
        return 8'(k);
    endfunction

    task automatic exp_byte(input logic [7:0] b, input string tag);
        exp_b_q.push_back(b);
        exp_b_tag.push_back(tag);
    endtask
    task automatic exp_pair(input int k, input logic [2:0] c, input string tag);
        exp_byte(hi_b(k, c), tag);
        exp_byte(lo_b(k), tag);
    endtask
    task automatic exp_conv(input logic [2:0] c, input string tag);
        exp_c_q.push_back(c);
        exp_c_tag.push_back(tag);
    endtask

    // Byte monitor
    always @(byte_ev) begin
        if (exp_b_q.size() == 0) begin
            check(1'b0, "unexpected read byte", got_byte, 0);
        end else begin
            logic [7:0] e;
            string t;
            e = exp_b_q.pop_front();
            t = exp_b_tag.pop_front();
            check(got_byte == e, t, got_byte, e);
        end
    end

    // Converter model with conversion monitor
    int         lat = 3;
    int         left = 0;
    int         n_done = 0;
    logic [2:0] model_ch = '0;

    always @(posedge clk) begin
        i_conv_done <= 1'b0;
        if (left == 1) begin
            i_conv_done  <= 1'b1;
            i_conv_value <= {model_ch, 1'b0, 8'(n_done)};
            i_alert      <= n_done[0];
            n_done       <= n_done + 1;
        end
        if (left > 0) left <= left - 1;
        if (o_conv_req) begin
            check(left == 0, "R10 launch while busy", left, 0);
            if (exp_c_q.size() == 0) begin
                check(1'b0, "unexpected conversion", o_conv_ch, 0);
            end else begin
                logic [2:0] e;
                string t;
                e = exp_c_q.pop_front();
                t = exp_c_tag.pop_front();
                check(o_conv_ch == e, t, o_conv_ch, e);
            end
            model_ch <= o_conv_ch;
            left     <= lat;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic bus_start();
        @(negedge clk); i_start = 1; @(negedge clk); i_start = 0; idle(1);
    endtask
    task automatic bus_stop();
        @(negedge clk); i_stop = 1; @(negedge clk); i_stop = 0; idle(1);
    endtask
    task automatic send_hdr(input bit rd);
        @(negedge clk); i_hdr_valid = 1; i_hdr_read = rd;
        @(negedge clk); i_hdr_valid = 0; idle(1);
    endtask
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); i_wr_valid = 1; i_wr_data = b;
        @(negedge clk); i_wr_valid = 0; idle(1);
    endtask
    task automatic get_byte(input bit nack);
        @(negedge clk); i_rd_req = 1;
        @(negedge clk); i_rd_req = 0;
        got_byte = o_rd_data;
        -> byte_ev;
        @(negedge clk); i_rd_ack_valid = 1; i_rd_nack = nack;
        @(negedge clk); i_rd_ack_valid = 0; i_rd_nack = 0;
        idle(8);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        check(o_rd_data == 8'h00, "reset rd_data", o_rd_data, 0);
        check(o_conv_req == 1'b0, "reset conv_req", o_conv_req, 0);
        rst_n = 1'b1;
        idle(2);

        // Pointer 7 first, then command 0x13: channels 0,1,4 (R1 R5)
        bus_start(); send_hdr(0); send_byte(8'h07); bus_stop();
        exp_conv(3'd0, "R1 first conversion on lowest channel");
        bus_start(); send_hdr(0); send_byte(8'h00); send_byte(8'h13);
        bus_start(); send_hdr(1);
        exp_conv(3'd1, "R4 next channel launched on high byte");
        exp_conv(3'd4, "R5 ascending channel order");
        exp_conv(3'd0, "R5 wrap to lowest channel");
        exp_conv(3'd1, "R5 continue after wrap");
        exp_pair(0, 3'd0, "R3 result bytes ch0");
        exp_pair(1, 3'd1, "R11 alert and ch1 result");
        exp_pair(2, 3'd4, "R5 ch4 id 100");
        exp_byte(hi_b(3, 3'd0), "R5 wrapped ch0 result");
        exp_byte(lo_b(3), "R7 last byte before NACK");
        repeat (3) begin get_byte(0); get_byte(0); end
        get_byte(0); get_byte(1);
        idle(10);
        bus_stop();
        // Pointer restored to 7 (R2, R12): reads zero word, no launch (R7)
        bus_start(); send_hdr(1);
        exp_byte(8'h00, "R2 pointer restored high");
        exp_byte(8'h00, "R12 other register low");
        get_byte(0); get_byte(1); bus_stop();

        // Mask 0xD2 with N_CH=6 -> channels 1,4; new pointer 0x01 (R2 R6)
        exp_conv(3'd1, "R6 upper mask bits dropped");
        exp_conv(3'd4, "R2 extra pointer byte keeps sequence");
        exp_conv(3'd1, "R5 wrap two channels");
        bus_start(); send_hdr(0); send_byte(8'h00); send_byte(8'hD2); send_byte(8'h01);
        bus_start(); send_hdr(1);
        exp_pair(5, 3'd1, "R4 pipelined ch1");
        exp_pair(6, 3'd4, "R4 pipelined ch4");
        get_byte(0); get_byte(0); get_byte(0); get_byte(1);
        idle(10); bus_stop();
        bus_start(); send_hdr(1);
        exp_pair(7, 3'd1, "R12 result register via new pointer");
        get_byte(0); get_byte(1); bus_stop();
        bus_start(); send_hdr(0); send_byte(8'h00); bus_stop();
        bus_start(); send_hdr(1);
        exp_byte(8'h00, "R6 command register high");
        exp_byte(8'h12, "R6 stored mask");
        get_byte(0); get_byte(1); bus_stop();

        // Zero mask after trimming (R6)
        bus_start(); send_hdr(0); send_byte(8'h00); send_byte(8'hC0); bus_stop();
        idle(10);
        bus_start(); send_hdr(1);
        exp_byte(8'h00, "R6 zero mask no entry high");
        exp_byte(8'h00, "R6 zero mask stored");
        get_byte(0); get_byte(1); bus_stop();

        // Stop instead of repeated start (R8)
        exp_conv(3'd0, "R8 only the first conversion");
        bus_start(); send_hdr(0); send_byte(8'h00); send_byte(8'h01); send_byte(8'h01);
        bus_stop(); idle(10);
        bus_start(); send_hdr(1);
        exp_pair(8, 3'd0, "R8 result after stop");
        exp_byte(hi_b(8, 3'd0), "R8 no new conversion");
        get_byte(0); get_byte(0); get_byte(1); bus_stop();

        // Idle timeout (R9): 125 cycles
        exp_conv(3'd1, "R9 entry conversion");
        exp_conv(3'd1, "R9 single channel repeat");
        bus_start(); send_hdr(0); send_byte(8'h00); send_byte(8'h02); send_byte(8'h01);
        bus_start(); send_hdr(1);
        exp_pair(9, 3'd1, "R9 result before timeout");
        get_byte(0); get_byte(0);
        idle(300);
        exp_pair(10, 3'd1, "R9 register read after timeout");
        get_byte(0); get_byte(1); bus_stop();

        // Slow converter: hold last result, deferred launch (R10)
        lat = 40;
        exp_conv(3'd0, "R10 entry conversion");
        exp_conv(3'd1, "R10 deferred launch");
        bus_start(); send_hdr(0); send_byte(8'h00); send_byte(8'h03); send_byte(8'h01);
        bus_start(); send_hdr(1);
        exp_pair(10, 3'd1, "R10 held last result");
        get_byte(0); get_byte(1);
        bus_stop(); idle(150);
        lat = 3;
        bus_start(); send_hdr(1);
        exp_pair(12, 3'd1, "R11 deferred result alert");
        get_byte(0); get_byte(1); bus_stop();

        idle(20);
        check(exp_b_q.size() == 0, "R3 all expected bytes read", exp_b_q.size(), 0);
        check(exp_c_q.size() == 0, "R4 all expected conversions seen", exp_c_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule